// File: doc/BRIEF.md
# Strobe-Driven 1-Bit Static Memory

This block is a 1024-location, 1-bit-wide storage array whose cycles are framed by a strobe input rather than by a free-running address bus. When the strobe goes low, the block captures the address and a cycle starts. When the strobe goes high again, the cycle ends and any pending write is committed. After the capture, the address pins are free to change.

The strobe is brought into the block's clock domain by a short synchroniser. Its two edges become one-cycle pulses, and every capture and commit happens on those pulses.

A read value is kept in an output latch, so it stays visible after the strobe returns high. A separate enable flag models a three-state driver. The flag is raised only when both active-low selects are low and no write is requested, which lets several such blocks share one data line. Holding the write enable low over several strobe cycles writes a run of locations.

Top module: `strobe_sram`

## Requirements
- R1: After reset, `dout_en_o` is 0 and `dout_o` is 0. `dout_en_o` stays 0 until a read cycle has loaded the output latch.
- R2: The address is sampled on the synchronised falling edge of `strobe_i`. Changes on `addr_i` after that point have no effect on the cycle in progress.
- R3: In a strobe-low cycle with `wr_ni` high, the output latch loads the captured location. The latch keeps that value after the strobe rises, and write cycles leave it unchanged.
- R4: At the synchronised rising edge of `strobe_i`, `din_i` is written to the captured address if `sel1_ni`, `sel2_ni` and `wr_ni` are all 0 at that moment.
- R5: If either select is 1 at the rising-edge pulse, memory contents are unchanged. This holds even when the select rises in the same input cycle as the strobe.
- R6: `dout_en_o` is 1 only when both selects were 0 in the previous clock. While it is 0, `dout_o` reads 0. Each select alone can disable the output.
- R7: While `wr_ni` is 0, `dout_en_o` is 0 from the next clock onward.
- R8: With `wr_ni` held low across consecutive strobe cycles, each cycle writes its own captured address.
- R9: The array is organised as 32 rows by 32 columns. `addr_i[9:5]` selects the row and `addr_i[4:0]` selects the column, and all 1024 locations are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 10 | Location address, captured at strobe fall |
| strobe_i | input | 1 | Cycle strobe; low frames a cycle |
| wr_ni | input | 1 | Active-low write enable |
| sel1_ni | input | 1 | Active-low select 1 |
| sel2_ni | input | 1 | Active-low select 2 |
| din_i | input | 1 | Write data, sampled at strobe rise |
| dout_o | output | 1 | Latched read data, 0 when disabled |
| dout_en_o | output | 1 | Output drive enable (three-state model) |

## Verification
A write commit and a select change can land on the same rising-edge pulse. The bench provokes this by raising one select in the same input cycle as the strobe, so the synchronised rise sees the select already high. It then judges the outcome by reading the location back under full selection: the old value must be returned.

The bench also changes the address a few clocks after the falling edge, before the output is sampled. The read must still return the captured location and not the one now on the pins.

// File: rtl/strobe_sram_pkg.sv
package strobe_sram_pkg;
  parameter int unsigned ADDR_W = 10;
  parameter int unsigned ROW_W  = 5;
  parameter int unsigned SYNC_N = 2;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o,
  output logic rise_o
);
  // idle level is high; one extra stage holds the previous level
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SYNC_N-1:0], strobe_i};
  end

  assign fall_o = sh_q[SYNC_N] & ~sh_q[SYNC_N-1];
  assign rise_o = ~sh_q[SYNC_N] & sh_q[SYNC_N-1];
endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_ni,
  input  logic              sel1_ni,
  input  logic              sel2_ni,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              active_o,
  output logic              we_o,
  output logic              ld_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              active_q;
  logic              sel_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      active_q <= 1'b0;
    end else begin
      if (fall_i) begin
        addr_q   <= addr_i;
        active_q <= 1'b1;
      end else if (rise_i) begin
        active_q <= 1'b0;
      end
    end
  end

  assign sel_ok   = ~sel1_ni & ~sel2_ni;
  assign we_o     = rise_i & active_q & sel_ok & ~wr_ni;
  assign ld_o     = active_q & wr_ni;
  assign addr_q_o = addr_q;
  assign active_o = active_q;
endmodule

// File: rtl/strobe_array.sv
module strobe_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ROW_W  = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              rd_o
);
  localparam int unsigned COL_W = ADDR_W - ROW_W;
  localparam int unsigned ROWS  = 1 << ROW_W;
  localparam int unsigned COLS  = 1 << COL_W;

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [COLS-1:0]  rows_w [ROWS];

  assign row = addr_i[ADDR_W-1:COL_W];
  assign col = addr_i[COL_W-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    logic            hit;
    assign hit = (row == ROW_W'(r));
    always_ff @(posedge clk_i) begin
      if (we_i && hit) row_q[col] <= din_i;
    end
    assign rows_w[r] = row_q;
  end

  assign rd_o = rows_w[row][col];
endmodule

// File: rtl/strobe_out.sv
module strobe_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic rd_i,
  input  logic wr_ni,
  input  logic sel1_ni,
  input  logic sel2_ni,
  output logic dout_o,
  output logic dout_en_o
);
  logic dout_q, valid_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= 1'b0;
      valid_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (ld_i) begin
        dout_q  <= rd_i;
        valid_q <= 1'b1;
      end
      oe_q <= valid_q & ~sel1_ni & ~sel2_ni & wr_ni;
    end
  end

  assign dout_o    = dout_q & oe_q;
  assign dout_en_o = oe_q;
endmodule

// File: rtl/strobe_sram.sv
module strobe_sram
  import strobe_sram_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned RW    = ROW_W,
  parameter int unsigned NSYNC = SYNC_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          strobe_i,
  input  logic          wr_ni,
  input  logic          sel1_ni,
  input  logic          sel2_ni,
  input  logic          din_i,
  output logic          dout_o,
  output logic          dout_en_o
);
  logic          fall_p, rise_p, active_q, we, ld, rd_bit;
  logic [AW-1:0] addr_q;

  strobe_edge #(.SYNC_N(NSYNC)) u_edge (
    .clk_i, .rst_ni, .strobe_i,
    .fall_o(fall_p), .rise_o(rise_p)
  );

  strobe_ctrl #(.ADDR_W(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .fall_i(fall_p), .rise_i(rise_p),
    .addr_i, .wr_ni, .sel1_ni, .sel2_ni,
    .addr_q_o(addr_q), .active_o(active_q),
    .we_o(we), .ld_o(ld)
  );

  strobe_array #(.ADDR_W(AW), .ROW_W(RW)) u_array (
    .clk_i, .we_i(we), .addr_i(addr_q), .din_i, .rd_o(rd_bit)
  );

  strobe_out u_out (
    .clk_i, .rst_ni, .ld_i(ld), .rd_i(rd_bit),
    .wr_ni, .sel1_ni, .sel2_ni,
    .dout_o, .dout_en_o
  );
endmodule

// File: rtl/strobe_sram_chk.sv
module strobe_sram_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_ni,
  input logic          sel1_ni,
  input logic          sel2_ni,
  input logic          din_i,
  input logic          dout_en_o,
  input logic          fall_p,
  input logic          rise_p,
  input logic          active_q,
  input logic [AW-1:0] addr_q,
  input logic          rd_bit
);
  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !fall_p) |=> $stable(addr_q));

  assert_write_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_p && active_q && !sel1_ni && !sel2_ni && !wr_ni) |=> (rd_bit == $past(din_i)));

  assert_write_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_p && (sel1_ni || sel2_ni)) |=> $stable(rd_bit));

  assert_oe_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> $past(!sel1_ni && !sel2_ni));

  assert_oe_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |=> !dout_en_o);
endmodule

bind strobe_sram strobe_sram_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .wr_ni, .sel1_ni, .sel2_ni, .din_i, .dout_en_o,
  .fall_p, .rise_p, .active_q, .addr_q, .rd_bit
);

// File: tb/sim_strobe_sram.sv
`timescale 1ns/1ps
module sim_strobe_sram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       strobe = 1'b1, wr_n = 1'b1, s1_n = 1'b0, s2_n = 1'b0, din = 1'b0;
  logic       dout, dout_en;
  logic       ref_m [1024];
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  strobe_sram u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .strobe_i(strobe),
    .wr_ni(wr_n), .sel1_ni(s1_n), .sel2_ni(s2_n), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // one strobe cycle; address scrambled after capture; output sampled mid-cycle
  task automatic cyc(input logic [9:0] a, input logic w, input logic d,
                     input logic x1, input logic x2, output logic q, output logic en);
    addr = a; wr_n = w; din = d; s1_n = x1; s2_n = x2;
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    addr = ~a;
    repeat (2) @(negedge clk);
    q = dout; en = dout_en;
    strobe = 1'b1;
    repeat (4) @(negedge clk);
    if (!w && !x1 && !x2) ref_m[a] = d;
  endtask

  task automatic wr(input logic [9:0] a, input logic d);
    logic q, en;
    cyc(a, 1'b0, d, 1'b0, 1'b0, q, en);
    wr_n = 1'b1;
  endtask

  task automatic rd_chk(input string tag, input logic [9:0] a);
    logic q, en;
    cyc(a, 1'b1, 1'b0, 1'b0, 1'b0, q, en);
    chk({tag, " en"}, en, 1'b1);
    chk({tag, " q"}, q, ref_m[a]);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset en", dout_en, 1'b0);
    chk("R1 reset q", dout, 1'b0);
  endtask

  task automatic t_corners;  // R9 row/col decode, R4 commit
    wr(10'd0, 1'b1); wr(10'd31, 1'b0); wr(10'd32, 1'b1);
    wr(10'd1023, 1'b1); wr(10'd992, 1'b0); wr(10'd33, 1'b0);
    rd_chk("R9 a0", 10'd0);     rd_chk("R9 a31", 10'd31);
    rd_chk("R9 a32", 10'd32);   rd_chk("R9 a1023", 10'd1023);
    rd_chk("R9 a992", 10'd992); rd_chk("R4 a33", 10'd33);
    wr(10'd0, 1'b0);
    rd_chk("R4 overwrite", 10'd0);
  endtask

  task automatic t_addr_change;  // R2
    wr(10'h155, 1'b1); wr(10'h2AA, 1'b0);
    rd_chk("R2 captured 155", 10'h155);
    rd_chk("R2 captured 2AA", 10'h2AA);
  endtask

  task automatic t_burst;  // R8, R7
    logic q, en;
    for (int i = 0; i < 6; i++) begin
      cyc(10'(100 + i), 1'b0, logic'(i % 2), 1'b0, 1'b0, q, en);
      chk("R7 burst en", en, 1'b0);
    end
    wr_n = 1'b1;
    for (int i = 0; i < 6; i++) rd_chk("R8 burst rd", 10'(100 + i));
  endtask

  task automatic t_deselect;  // R6, R5
    logic q, en;
    rd_chk("R6 prime", 10'd31);
    cyc(10'd32, 1'b1, 1'b0, 1'b1, 1'b0, q, en);
    chk("R6 s1 en", en, 1'b0); chk("R6 s1 q", q, 1'b0);
    cyc(10'd32, 1'b1, 1'b0, 1'b0, 1'b1, q, en);
    chk("R6 s2 en", en, 1'b0); chk("R6 s2 q", q, 1'b0);
    cyc(10'd32, 1'b0, 1'b0, 1'b1, 1'b0, q, en);
    cyc(10'd32, 1'b0, 1'b0, 1'b0, 1'b1, q, en);
    wr_n = 1'b1;
    rd_chk("R5 blocked", 10'd32);
  endtask

  task automatic t_race;  // R5: select rises with strobe
    addr = 10'd1023; wr_n = 1'b0; din = 1'b0; s1_n = 1'b0; s2_n = 1'b0;
    strobe = 1'b0;
    repeat (6) @(negedge clk);
    strobe = 1'b1; s2_n = 1'b1;
    repeat (4) @(negedge clk);
    s2_n = 1'b0; wr_n = 1'b1;
    rd_chk("R5 race", 10'd1023);
  endtask

  task automatic t_hold;  // R3
    logic q, en;
    rd_chk("R3 read", 10'd992);
    repeat (10) @(negedge clk);
    chk("R3 hold q", dout, ref_m[10'd992]);
    rd_chk("R3 read1", 10'd1023);
    cyc(10'd500, 1'b0, 1'b0, 1'b0, 1'b0, q, en);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 after write en", dout_en, 1'b1);
    chk("R3 after write q", dout, 1'b1);
    s1_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 late deselect", dout_en, 1'b0);
    s1_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 reselect q", dout, 1'b1);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_addr_change();
    t_burst();
    t_deselect();
    t_race();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule